// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Arbitration

This block is the digital control side of a successive-approximation converter. A small register bus programs a mode register and a channel register and reads back a result register. Conversions start on a software request or an external trigger. Each conversion is a fixed number of busy cycles. In the last busy cycle the block takes a digital sample of the selected channel from a flat input port.

The block owns the comparator power-down control. It also enforces a settling delay after power-up, and no conversion starts until that delay has elapsed. Several events can land on the same cycle as a result update. A result read is served first, and the update waits for it. A trigger that arrives during the busy period is dropped. A register write just after an update still lets the update through, but it cancels that update's interrupt.

Top module: `adc_ctrl`

## Requirements
- R1: After reset, mode reads 0x01 (power-down set), channel reads 0, result reads 0, and `busy`, `comp_ready` and `eoc_irq` are low.
- R2: Address 0 is the mode register, with bit 7 enable, bit 6 trigger mode, bit 1 continuous and bit 0 power-down; every other bit reads 0. Address 1 is the channel register. Address 2 is the 10-bit result. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: `comp_ready` rises exactly STAB_CYC cycles after the edge that clears power-down. It drops in the cycle after power-down is set again.
- R4: A mode write with enable=1, trigger mode=0 and power-down=0 requests one conversion. The conversion starts in the first cycle that is idle with `comp_ready` high, and keeps `busy` high for CONV_CYC cycles. The result is the selected channel's sample in the last busy cycle. `eoc_irq` is a single-cycle pulse two cycles after that last busy cycle. When the converter is already ready, this pulse comes CONV_CYC+3 cycles after the write cycle.
- R5: A channel write with a value of 12 or more leaves the channel register unchanged.
- R6: In trigger mode, `ext_trig` high in an idle, ready cycle starts a conversion in that same cycle. A trigger during a busy cycle is ignored, and this includes the last busy cycle.
- R7: A result read in the cycle where a result would be written returns the old value. The write then happens in the next cycle that has no result read, and the interrupt moves back by the same amount.
- R8: A mode or channel write in the cycle right after a result write lets the result be stored but cancels that result's `eoc_irq`.
- R9: In continuous mode, a new conversion starts right after each completed one, so interrupts come every CONV_CYC cycles.
- R10: Clearing enable or setting power-down during a conversion aborts it. The result is not updated and no interrupt is raised.
- R11: A valid channel write during a conversion restarts the conversion from its first cycle on the new channel. The interrupt then comes CONV_CYC+2 cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | RES | Registered read data |
| ext_trig | input | 1 | External conversion trigger |
| ana_in | input | NCH*RES | Digital samples, channel k at bits k*RES upward |
| busy | output | 1 | Conversion in progress |
| comp_ready | output | 1 | Comparator powered and settled |
| eoc_irq | output | 1 | End-of-conversion pulse |

## Verification
A wrong conversion counter shows up as an interrupt that is off by whole cycles. Because the bench times each pulse to the exact cycle, such a fault is caught on the first conversion after the fault. A lost collision deferral shows up as a new value returned by a read that should have seen the old one, or as an interrupt one cycle early. A fault in the interrupt suppression shows up within two cycles of the result write, as a stray or missing pulse. A wrong settling counter moves the rise of `comp_ready`, and it also moves the interrupt of the first conversion after power-up.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CHAN = 2'd1;
  localparam logic [1:0] A_RES  = 2'd2;

  localparam int EN_BIT   = 7;
  localparam int TRIG_BIT = 6;
  localparam int CONT_BIT = 1;
  localparam int PD_BIT   = 0;

  typedef struct packed {
    logic en;
    logic trig;
    logic cont;
    logic pd;
  } mode_t;

  localparam mode_t MODE_RST = '{en: 1'b0, trig: 1'b0, cont: 1'b0, pd: 1'b1};
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int RES  = 10,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic [RES-1:0]  result_q,
  output mode_t           mode_q,
  output logic [CH_W-1:0] ch_q,
  output logic            mode_wr,
  output logic            ch_wr,
  output logic            start_cmd,
  output logic            rd_res,
  output logic [RES-1:0]  bus_rdata
);
  logic [7:0] mode_byte;

  assign mode_wr   = bus_wr && (bus_addr == A_MODE);
  assign ch_wr     = bus_wr && (bus_addr == A_CHAN) && (int'(bus_wdata) < NCH);
  assign start_cmd = mode_wr && bus_wdata[EN_BIT] && !bus_wdata[TRIG_BIT] && !bus_wdata[PD_BIT];
  assign rd_res    = bus_rd && (bus_addr == A_RES);

  always_comb begin
    mode_byte           = '0;
    mode_byte[EN_BIT]   = mode_q.en;
    mode_byte[TRIG_BIT] = mode_q.trig;
    mode_byte[CONT_BIT] = mode_q.cont;
    mode_byte[PD_BIT]   = mode_q.pd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RST;
      ch_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (mode_wr)
        mode_q <= '{en: bus_wdata[EN_BIT], trig: bus_wdata[TRIG_BIT],
                    cont: bus_wdata[CONT_BIT], pd: bus_wdata[PD_BIT]};
      if (ch_wr)
        ch_q <= bus_wdata[CH_W-1:0];
      if (bus_rd) begin
        case (bus_addr)
          A_MODE:  bus_rdata <= RES'(mode_byte);
          A_CHAN:  bus_rdata <= RES'(ch_q);
          A_RES:   bus_rdata <= result_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R5
  bad_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CHAN && int'(bus_wdata) >= NCH) |=> $stable(ch_q));
endmodule

// File: rtl/adc_ctrl_stab.sv
module adc_ctrl_stab #(
  parameter int STAB_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  output logic ready
);
  localparam int SW = $clog2(STAB_CYC + 1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || pd)
      cnt <= '0;
    else if (cnt != SW'(STAB_CYC))
      cnt <= cnt + SW'(1);
  end

  assign ready = !pd && (cnt == SW'(STAB_CYC));

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> pd);
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int CONV_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pd,
  input  logic trig_mode,
  input  logic cont,
  input  logic ready,
  input  logic ext_trig,
  input  logic start_cmd,
  input  logic ch_wr,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic sw_req, run_ok, start;

  assign run_ok = en && !pd && ready;
  assign start  = !busy && run_ok && (sw_req || (trig_mode && ext_trig));
  assign done   = busy && run_ok && !ch_wr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      sw_req <= 1'b0;
    end else begin
      sw_req <= start_cmd || (sw_req && !start && en);
      if (busy) begin
        if (!run_ok)
          busy <= 1'b0;
        else if (ch_wr)
          cnt <= '0;
        else if (cnt == LAST) begin
          cnt  <= '0;
          busy <= cont;
        end else
          cnt <= cnt + CNT_W'(1);
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> !busy);
  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && run_ok && ch_wr) |=> (busy && cnt == '0));
  // R6
  trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && run_ok && !ch_wr && cnt != LAST) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
  // R4
  start_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cnt == '0);
endmodule

// File: rtl/adc_ctrl_result.sv
module adc_ctrl_result #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           done,
  input  logic [RES-1:0] sample,
  input  logic           rd_res,
  input  logic           reg_wr,
  output logic [RES-1:0] result_q,
  output logic           eoc_irq
);
  logic [RES-1:0] hold;
  logic pend, irq_arm, wr_now;

  assign wr_now = (done || pend) && !rd_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      hold     <= '0;
      pend     <= 1'b0;
      irq_arm  <= 1'b0;
      eoc_irq  <= 1'b0;
    end else begin
      if (done)
        hold <= sample;
      if (wr_now)
        result_q <= done ? sample : hold;
      pend    <= (done || pend) && rd_res;
      irq_arm <= wr_now;
      eoc_irq <= irq_arm && !reg_wr;
    end
  end

  // R7
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    rd_res |=> $stable(result_q));
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |=> !eoc_irq);
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int NCH      = 12,
  parameter int RES      = 10,
  parameter int CONV_CYC = 10,
  parameter int CLK_MHZ  = 125,
  parameter int STAB_US  = 5,
  parameter int STAB_CYC = CLK_MHZ * STAB_US
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [RES-1:0]     bus_rdata,
  input  logic               ext_trig,
  input  logic [NCH*RES-1:0] ana_in,
  output logic               busy,
  output logic               comp_ready,
  output logic               eoc_irq
);
  localparam int CH_W = $clog2(NCH);

  mode_t           mode_q;
  logic [CH_W-1:0] ch_q;
  logic [RES-1:0]  result_q, sample;
  logic mode_wr, ch_wr, start_cmd, rd_res, done;

  assign sample = ana_in[int'(ch_q)*RES +: RES];

  adc_ctrl_regs #(.NCH(NCH), .RES(RES), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .result_q(result_q), .mode_q(mode_q), .ch_q(ch_q),
    .mode_wr(mode_wr), .ch_wr(ch_wr), .start_cmd(start_cmd), .rd_res(rd_res),
    .bus_rdata(bus_rdata));

  adc_ctrl_stab #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk(clk), .rst(rst), .pd(mode_q.pd), .ready(comp_ready));

  adc_ctrl_seq #(.CONV_CYC(CONV_CYC)) u_seq (
    .clk(clk), .rst(rst), .en(mode_q.en), .pd(mode_q.pd), .trig_mode(mode_q.trig),
    .cont(mode_q.cont), .ready(comp_ready), .ext_trig(ext_trig), .start_cmd(start_cmd),
    .ch_wr(ch_wr), .busy(busy), .done(done));

  adc_ctrl_result #(.RES(RES)) u_res (
    .clk(clk), .rst(rst), .done(done), .sample(sample), .rd_res(rd_res),
    .reg_wr(mode_wr || ch_wr), .result_q(result_q), .eoc_irq(eoc_irq));
endmodule

// File: tb/adc_ctrl_test.sv
`timescale 1ns/1ps
module adc_ctrl_test;
  localparam int NCH = 12, RES = 10, CONV = 10, STAB = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ext_trig = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [RES-1:0] bus_rdata;
  logic [NCH*RES-1:0] ana_in;
  logic busy, comp_ready, eoc_irq;

  int cyc = 0, irq_n = 0, irq_at = 0;
  int checks = 0, fails = 0;

  adc_ctrl #(.NCH(NCH), .RES(RES), .CONV_CYC(CONV), .STAB_CYC(STAB)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .ana_in(ana_in),
    .busy(busy), .comp_ready(comp_ready), .eoc_irq(eoc_irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eoc_irq && !rst) begin
      irq_n  <= irq_n + 1;
      irq_at <= cyc;
    end
  end

  function automatic int smp(int ch, int seed);
    return (ch * 83 + seed * 151 + 17) % 1024;
  endfunction

  task automatic load_ana(int seed);
    for (int k = 0; k < NCH; k++) ana_in[k*RES +: RES] = RES'(smp(k, seed));
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_irq();
    int base = irq_n;
    for (int k = 0; k < 300 && irq_n == base; k++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int v, t0, t1, n, base;
    load_ana(0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(comp_ready), 0);
    check("R1 irq", int'(eoc_irq), 0);
    rd(2'd0, v); check("R1 mode", v, 1);
    rd(2'd1, v); check("R1 chan", v, 0);
    rd(2'd2, v); check("R1 result", v, 0);

    // R3 settle time, then R4 deferred start
    t0 = cyc; wr(2'd0, 8'h80);
    n = 0;
    while (!comp_ready && n < 1000) begin @(negedge clk); n++; end
    check("R3 settle cycles", n, STAB);
    wait_irq();
    check("R4 start after settle", irq_at - t0, STAB + 13);
    check("R4 pulse width", int'(eoc_irq), 0);
    rd(2'd2, v); check("R4 first result", v, smp(0, 0));
    rd(2'd0, v); check("R2 mode readback", v, 8'h80);

    // R5 channel range
    wr(2'd1, 8'd13); rd(2'd1, v); check("R5 chan 13 ignored", v, 0);
    wr(2'd1, 8'd11); rd(2'd1, v); check("R5 chan 11 taken", v, 11);
    wr(2'd1, 8'd255); rd(2'd1, v); check("R5 chan 255 ignored", v, 11);

    // R4 sweep of all channels under two sample sets
    for (int s = 1; s <= 2; s++) begin
      load_ana(s);
      for (int k = 0; k < NCH; k++) begin
        wr(2'd1, 8'(k));
        t0 = cyc; wr(2'd0, 8'h80);
        wait_irq();
        check("R4 latency", irq_at - t0, CONV + 3);
        rd(2'd2, v); check("R4 result", v, smp(k, s));
      end
    end

    // R7 read in the write cycle
    load_ana(3); wr(2'd1, 8'd5);
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + CONV + 1);
    rd(2'd2, v); check("R7 old value", v, smp(11, 2));
    wait_irq();
    check("R7 irq delayed", irq_at - t0, CONV + 4);
    rd(2'd2, v); check("R7 new value", v, smp(5, 3));

    // R8 channel write right after result write
    load_ana(4); base = irq_n;
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + CONV + 2); wr(2'd1, 8'd6);
    wait_to(t0 + 30);
    check("R8 chan write kills irq", irq_n, base);
    rd(2'd2, v); check("R8 result stored", v, smp(5, 4));

    // R8 mode write right after result write
    load_ana(5);
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + CONV + 2); wr(2'd0, 8'h00);
    wait_to(t0 + 30);
    check("R8 mode write kills irq", irq_n, base);
    rd(2'd2, v); check("R8 result stored 2", v, smp(6, 5));

    // R10 abort by disable
    load_ana(6);
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + 5); wr(2'd0, 8'h00);
    wait_to(t0 + 30);
    check("R10 busy low", int'(busy), 0);
    check("R10 no irq", irq_n, base);
    rd(2'd2, v); check("R10 result kept", v, smp(6, 5));

    // R10 abort by power-down, R3 ready drop and re-settle
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + 5); wr(2'd0, 8'h81);
    check("R3 ready drops", int'(comp_ready), 0);
    wait_to(t0 + 30);
    check("R10 pd no irq", irq_n, base);
    rd(2'd2, v); check("R10 pd result kept", v, smp(6, 5));
    wr(2'd0, 8'h00);
    n = 0;
    while (!comp_ready && n < 1000) begin @(negedge clk); n++; end
    check("R3 re-settle cycles", n, STAB);

    // R11 channel write restarts
    load_ana(7); wr(2'd1, 8'd2);
    t0 = cyc; wr(2'd0, 8'h80);
    wait_to(t0 + 5); wr(2'd1, 8'd7);
    wait_irq();
    check("R11 restart latency", irq_at - (t0 + 5), CONV + 2);
    wait_to(t0 + 45);
    check("R11 single irq", irq_n, base + 1);
    rd(2'd2, v); check("R11 new channel", v, smp(7, 7));

    // R6 trigger mode
    load_ana(8); wr(2'd1, 8'd9); base = irq_n;
    wr(2'd0, 8'hC0);
    repeat (3) @(negedge clk);
    check("R6 no start without trigger", int'(busy), 0);
    t1 = cyc; pulse_trig();
    wait_to(t1 + 5); pulse_trig();
    wait_to(t1 + CONV); pulse_trig();
    check("R6 trigger in last busy cycle ignored", int'(busy), 0);
    wait_to(t1 + 40);
    check("R6 one conversion", irq_n, base + 1);
    check("R6 latency", irq_at - t1, CONV + 2);
    rd(2'd2, v); check("R6 result", v, smp(9, 8));

    // R9 continuous mode
    load_ana(9);
    t0 = cyc; wr(2'd0, 8'h82);
    wait_irq();
    check("R9 first latency", irq_at - t0, CONV + 3);
    t1 = irq_at;
    rd(2'd2, v); check("R9 first result", v, smp(9, 9));
    load_ana(10);
    wait_irq();
    check("R9 spacing", irq_at - t1, CONV);
    rd(2'd2, v); check("R9 second result", v, smp(9, 10));
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 stops when disabled", int'(busy), 0);

    summary();
  end
endmodule